// File: doc/BRIEF.md
# Timekeeping-domain clock control register

This block holds one 32-bit control and status word for a low-power timekeeping domain, together with the clock-selection logic that the word drives. Software writes the word through a single-cycle write strobe and reads it back combinationally. The word chooses the timekeeping clock from one of four settings: no clock, a slow external oscillator, a slow internal oscillator, or the fast clock divided by 32. An enable bit gates the chosen clock, and a separate low-speed output pin can carry either slow oscillator.

The fast clock `clk_i` clocks the whole block. Both slow oscillators are sampled through synchronizer stages. A monitor counts fast-clock cycles between rising edges of the slow external oscillator and raises a read-only failure flag when no edge arrives within a set timeout. Two fields guard themselves against careless software. The source field takes only its first nonzero value. The monitor enable can be cleared only after a failure has been flagged. A domain-reset bit returns every field to zero while it is held at 1.

Top module: `bdclk_ctrl`

## Requirements
- R1: After `rst_ni` is released, `rdata_o` reads 0 and both `rtc_clk_o` and `lsco_o` are low.
- R2: Only bits 25 (output select), 24 (output enable), 16 (domain reset), 15 (clock enable), 9:8 (source), 6 (failure flag) and 5 (monitor enable) can be nonzero. A write of all ones with bit 16 clear, made when no failure is flagged, reads back 0x03008320.
- R3: The source field (bits 9:8: 00 none, 01 slow external, 10 slow internal, 11 fast clock divided by 32) accepts a write only while it holds 00 or while the failure flag is set. Otherwise the field keeps its value.
- R4: Writing 1 to bit 16 clears every other field and the failure flag, and the word reads 0x00010000. While bit 16 is 1, a write changes only bit 16.
- R5: With bit 15 set, `rtc_clk_o` follows the selected source three clock edges after a change at the input pin. Source 00 holds it low.
- R6: With bit 15 clear, `rtc_clk_o` is low.
- R7: With bit 24 set, `lsco_o` follows the slow internal oscillator when bit 25 is 0 and the slow external oscillator when bit 25 is 1. With bit 24 clear it is low.
- R8: The failure flag (bit 6) ignores writes. It sets when the monitor is enabled and `TIMEOUT` fast cycles pass without a rising edge of the synchronized external oscillator. It stays clear while that oscillator toggles faster than this.
- R9: Once bit 5 is 1, writing 0 to it has no effect unless the failure flag is 1. In that case the write clears it.
- R10: While the failure flag is 1, the source field accepts a new value even though it is nonzero.
- R11: When the failure flag is 1 and the source is 01, `rtc_clk_o` is held low.
- R12: With source 11, `rtc_clk_o` has a period of 32 fast cycles and is high for 16 of them.
- R13: The failure flag stays set until a domain reset, even if the oscillator resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock: clocks the bus, the divider and the monitor |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Current control and status word |
| lsi_i | input | 1 | Slow internal oscillator |
| lse_i | input | 1 | Slow external oscillator |
| rtc_clk_o | output | 1 | Gated timekeeping clock |
| lsco_o | output | 1 | Low-speed clock output pin |

## Verification
The bench tries to rewrite a locked source field. A design that ignored the lock would let the timekeeping clock be switched to another source. It writes 0 to the monitor enable both before and after a failure, which catches an enable that never clears or one that clears too early. It stops the external oscillator while that oscillator drives the output. A design without the forced-low path would leave the clock stuck at its last level. It also checks that the failure flag survives a restarted oscillator, and that writes made while the domain is in reset do not leak into the fields.

// File: rtl/bdclk_pkg.sv
package bdclk_pkg;
  localparam int B_LSCO_SEL = 25;
  localparam int B_LSCO_EN  = 24;
  localparam int B_DOM_RST  = 16;
  localparam int B_CLK_EN   = 15;
  localparam int B_SRC_LO   = 8;
  localparam int B_FAIL     = 6;
  localparam int B_MON_EN   = 5;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'b00,
    SRC_LSE     = 2'b01,
    SRC_LSI     = 2'b10,
    SRC_HSE_DIV = 2'b11
  } src_e;

  typedef struct packed {
    logic lsco_sel;
    logic lsco_en;
    logic dom_rst;
    logic clk_en;
    src_e src;
    logic mon_en;
  } ctl_t;

  function automatic logic [31:0] pack_rd(ctl_t c, logic fail);
    logic [31:0] r;
    r = '0;
    r[B_LSCO_SEL]          = c.lsco_sel;
    r[B_LSCO_EN]           = c.lsco_en;
    r[B_DOM_RST]           = c.dom_rst;
    r[B_CLK_EN]            = c.clk_en;
    r[B_SRC_LO+1:B_SRC_LO] = c.src;
    r[B_FAIL]              = fail;
    r[B_MON_EN]            = c.mon_en;
    return r;
  endfunction
endpackage

// File: rtl/bdclk_sync.sv
module bdclk_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bdclk_div.sv
module bdclk_div #(
  parameter int DIV_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // msb of a free-running counter: exact 50% duty
  assign div_o = cnt_q[DIV_W-1];
endmodule

// File: rtl/bdclk_lse_mon.sv
module bdclk_lse_mon #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic lse_i,
  output logic fail_o
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;
  logic          prev_q;
  logic          fail_q;
  logic          rise;

  assign rise = lse_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      prev_q <= lse_i;
      if (clr_i) begin
        cnt_q  <= '0;
        fail_q <= 1'b0;
      end else if (!en_i || fail_q || rise) begin
        cnt_q <= '0;
      end else if (cnt_q == LIMIT) begin
        fail_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/bdclk_regs.sv
module bdclk_regs
  import bdclk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        fail_i,
  output ctl_t        ctl_o
);
  ctl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      if (q.dom_rst) begin
        // domain held in reset: only the reset bit is writable
        q         <= '0;
        q.dom_rst <= wdata_i[B_DOM_RST];
      end else if (wdata_i[B_DOM_RST]) begin
        q         <= '0;
        q.dom_rst <= 1'b1;
      end else begin
        q.lsco_sel <= wdata_i[B_LSCO_SEL];
        q.lsco_en  <= wdata_i[B_LSCO_EN];
        q.clk_en   <= wdata_i[B_CLK_EN];
        if (q.src == SRC_NONE || fail_i)
          q.src <= src_e'(wdata_i[B_SRC_LO+1:B_SRC_LO]);
        if (wdata_i[B_MON_EN])
          q.mon_en <= 1'b1;
        else if (fail_i)
          q.mon_en <= 1'b0;
      end
    end
  end

  assign ctl_o = q;
endmodule

// File: rtl/bdclk_ctrl.sv
module bdclk_ctrl
  import bdclk_pkg::*;
#(
  parameter int TIMEOUT     = 64,
  parameter int DIV_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        lsi_i,
  input  logic        lse_i,
  output logic        rtc_clk_o,
  output logic        lsco_o
);
  ctl_t ctl;
  logic fail;
  logic lsi_s, lse_s;
  logic div_clk;
  logic mon_clr;
  logic rtc_d, rtc_q, lsco_q;
  logic unused_wdata;

  assign unused_wdata = ^{wdata_i[31:26], wdata_i[23:17], wdata_i[14:10],
                          wdata_i[7:6], wdata_i[4:0]};

  bdclk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lse_i, lsi_i}),
    .q_o   ({lse_s, lsi_s})
  );

  bdclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_o (div_clk)
  );

  // clear the flag on the same edge that the reset bit is written
  assign mon_clr = ctl.dom_rst | (wr_i & wdata_i[B_DOM_RST]);

  bdclk_lse_mon #(.TIMEOUT(TIMEOUT)) u_mon (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mon_clr),
    .en_i  (ctl.mon_en),
    .lse_i (lse_s),
    .fail_o(fail)
  );

  bdclk_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .fail_i (fail),
    .ctl_o  (ctl)
  );

  always_comb begin
    unique case (ctl.src)
      SRC_LSE:     rtc_d = lse_s & ~fail;
      SRC_LSI:     rtc_d = lsi_s;
      SRC_HSE_DIV: rtc_d = div_clk;
      default:     rtc_d = 1'b0;
    endcase
    if (!ctl.clk_en) rtc_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtc_q  <= 1'b0;
      lsco_q <= 1'b0;
    end else begin
      rtc_q  <= rtc_d;
      lsco_q <= ctl.lsco_en & (ctl.lsco_sel ? lse_s : lsi_s);
    end
  end

  assign rtc_clk_o = rtc_q;
  assign lsco_o    = lsco_q;
  assign rdata_o   = pack_rd(ctl, fail);
endmodule

// File: rtl/bdclk_ctrl_chk.sv
module bdclk_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        rtc_clk_o,
  input logic        lsco_o
);
  logic drst_wr;
  logic unused_wd;
  assign drst_wr   = wr_i & wdata_i[16];
  assign unused_wd = ^{wdata_i[31:17], wdata_i[15:0]};

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~32'h0301_8360) == 32'h0);  // R2

  AST_SRC_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[9:8] != 2'b00 && !rdata_o[6] && !rdata_o[16] && !drst_wr)
      |=> rdata_o[9:8] == $past(rdata_o[9:8]));  // R3

  AST_DRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[16] |-> (rdata_o & ~32'h0001_0000) == 32'h0);  // R4

  AST_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rdata_o[15]) |-> !rtc_clk_o);  // R6

  AST_LSCO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rdata_o[24]) |-> !lsco_o);  // R7

  AST_MON_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[5] && !rdata_o[6] && !drst_wr) |=> rdata_o[5]);  // R9

  AST_FAIL_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rdata_o[6]) && $past(rdata_o[9:8]) == 2'b01) |-> !rtc_clk_o);  // R11

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[6] && !drst_wr) |=> rdata_o[6]);  // R13
endmodule

bind bdclk_ctrl bdclk_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .rtc_clk_o(rtc_clk_o),
  .lsco_o   (lsco_o)
);

// File: tb/bdclk_ctrl_tb.sv
`timescale 1ns/1ps
module bdclk_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lsi = 1'b0;
  logic        lse;
  logic        lse_man = 1'b0;
  logic        lse_osc = 1'b0;
  logic        lse_run = 1'b1;
  logic        rtc, lsco;
  int          n_chk = 0;
  int          n_bad = 0;
  int          osc_cnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign lse = lse_run ? lse_osc : lse_man;

  always @(negedge clk) begin
    osc_cnt <= (osc_cnt == 9) ? 0 : osc_cnt + 1;
    if (osc_cnt == 9) lse_osc <= ~lse_osc;
  end

  bdclk_ctrl u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_i     (wr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .lsi_i    (lsi),
    .lse_i    (lse),
    .rtc_clk_o(rtc),
    .lsco_o   (lsco)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
    wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {write data, expected read-back}
  localparam logic [63:0] VEC [10] = '{
    {32'hFFFF_FFFF, 32'h0001_0000},  // R4 enter domain reset
    {32'hFFFE_FFFF, 32'h0000_0000},  // R4 writes ignored while in reset
    {32'hFFFE_FFFF, 32'h0300_8320},  // R2 writable bits only
    {32'h0000_0100, 32'h0000_0320},  // R3 locked source, R9 sticky enable
    {32'h0001_0000, 32'h0001_0000},  // R4
    {32'h0000_0000, 32'h0000_0000},  // R4 leave reset
    {32'h0000_0040, 32'h0000_0000},  // R8 flag ignores writes
    {32'h0000_0000, 32'h0000_0000},  // R3 writing 00 does not lock
    {32'h0000_0200, 32'h0000_0200},  // R3 first source taken
    {32'h0000_0100, 32'h0000_0200}   // R3 second source ignored
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected 0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int ones, rises;
    logic prev;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 rtc", {31'h0, rtc}, 32'h0);
    chk("R1 lsco", {31'h0, lsco}, 32'h0);

    for (int i = 0; i < 10; i++) begin
      wr_word(VEC[i][63:32]);
      chk($sformatf("vector %0d R2/R3/R4/R8/R9", i), rdata, VEC[i][31:0]);
    end

    // R6: source 10 chosen, clock enable clear
    lsi = 1'b1;
    idle(5);
    chk("R6 gated low", {31'h0, rtc}, 32'h0);

    // R5: internal oscillator path
    wr_word(32'h0000_8200);
    idle(5);
    chk("R5 lsi high", {31'h0, rtc}, 32'h1);
    lsi = 1'b0;
    idle(5);
    chk("R5 lsi low", {31'h0, rtc}, 32'h0);

    // R7: low-speed output
    lsi = 1'b1;
    lse_run = 1'b0;
    lse_man = 1'b0;
    wr_word(32'h0100_8200);
    idle(5);
    chk("R7 out lsi", {31'h0, lsco}, 32'h1);
    wr_word(32'h0300_8200);
    idle(5);
    chk("R7 out lse low", {31'h0, lsco}, 32'h0);
    lse_man = 1'b1;
    idle(5);
    chk("R7 out lse high", {31'h0, lsco}, 32'h1);
    wr_word(32'h0200_8200);
    idle(5);
    chk("R7 out disabled", {31'h0, lsco}, 32'h0);

    // R5: external oscillator path
    wr_word(32'h0001_0000);
    wr_word(32'h0000_0000);
    wr_word(32'h0000_8100);
    idle(5);
    chk("R5 lse high", {31'h0, rtc}, 32'h1);
    lse_man = 1'b0;
    idle(5);
    chk("R5 lse low", {31'h0, rtc}, 32'h0);

    // R5: source 00 gives no clock
    wr_word(32'h0001_0000);
    wr_word(32'h0000_0000);
    wr_word(32'h0000_8000);
    ones = 0;
    for (int k = 0; k < 40; k++) begin
      lsi = k[2];
      @(negedge clk);
      ones += int'(rtc);
    end
    chk("R5 none stays low", ones, 0);

    // R12: divided fast clock
    wr_word(32'h0001_0000);
    wr_word(32'h0000_0000);
    wr_word(32'h0000_8300);
    idle(4);
    ones = 0;
    rises = 0;
    prev = rtc;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      ones += int'(rtc);
      if (rtc && !prev) rises++;
      prev = rtc;
    end
    chk("R12 high cycles", ones, 32);
    chk("R12 rising edges", rises, 2);

    // R8/R9/R10/R11/R13: failure path
    wr_word(32'h0001_0000);
    wr_word(32'h0000_0000);
    lse_run = 1'b1;
    wr_word(32'h0000_8120);
    idle(200);
    chk("R8 no false flag", rdata, 32'h0000_8120);
    wr_word(32'h0000_8100);
    chk("R9 enable stays without flag", rdata, 32'h0000_8120);
    lse_run = 1'b0;
    lse_man = 1'b0;
    idle(150);
    chk("R8 flag set", rdata, 32'h0000_8160);
    lse_man = 1'b1;
    idle(5);
    chk("R11 forced low", {31'h0, rtc}, 32'h0);
    wr_word(32'h0000_8200);
    chk("R10/R9 source change and enable clear", rdata, 32'h0000_8240);
    lse_run = 1'b1;
    idle(100);
    chk("R13 flag held", rdata, 32'h0000_8240);
    wr_word(32'h0001_0000);
    chk("R13 cleared by domain reset", rdata, 32'h0001_0000);
    wr_word(32'h0000_0000);
    chk("R4 all clear", rdata, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule